// File: doc/BRIEF.md
# Sv32/Sv39 Page Table Walker

This block translates one virtual address at a time into a physical address. It reads page table entries through a simple request/response memory port and applies the full set of leaf legality and permission rules. A request carries the access kind, the current privilege, the supervisor-user-access and make-executable-readable bits, the modify-privilege bit with its saved privilege, and a translation control word made of a scheme selector and a root page number. When it finishes, the walker raises a one-cycle `done`. At that point it presents either a physical address with read/write/execute grants, or a fault. A fault is marked as an access fault when it comes from a memory error and as a page fault otherwise. When a successful leaf lacks its accessed bit, or a store finds the dirty bit clear, the walker writes the updated entry back before it completes.

The controller is one state machine with eight states. `ST_IDLE` accepts a request and goes to `ST_CHECK`. `ST_CHECK` resolves bypass, an unsupported scheme or a non-canonical address straight to `ST_DONE`, and otherwise goes to `ST_READ`. `ST_READ` issues a one-cycle read and moves to `ST_WAIT_RD`. `ST_WAIT_RD` waits for the response. It goes to `ST_DONE` on an error and to `ST_EVAL` otherwise. `ST_EVAL` returns to `ST_READ` for a pointer above the last level. It goes to `ST_DONE` on a fault or on a clean leaf, and to `ST_WRITE` when the leaf must be updated. `ST_WRITE` issues the write and moves to `ST_WAIT_WR`, which goes to `ST_DONE` on the acknowledge. `ST_DONE` pulses `done` and returns to `ST_IDLE`.

Top module: `ptw_walker`

## Requirements
- R1: Scheme code 0 (bare) completes without any memory access, with the physical address equal to the low PA_W bits of the virtual address and read, write and execute all granted. Scheme code 3 is unsupported and gives a page fault without any memory access.
- R2: Privilege is encoded U=0, S=1, M=3, and access kind is encoded load=0, store=1, fetch=2. An effective privilege of M bypasses translation in the same way as R1. For loads and stores made in M with the modify-privilege bit set, the effective privilege is the saved privilege input. Fetches ignore the modify-privilege bit.
- R3: Under scheme code 2 (Sv39), if virtual address bits 63..38 are not all equal, the result is a page fault with no memory access.
- R4: Under Sv39 (code 2) the walk has 3 levels, each with a 9-bit index, and 8-byte entries. Under Sv32 (code 1) it has 2 levels, each with a 10-bit index, and 4-byte entries. The first entry is read at root<<12 plus the top-level index times the entry size. Each later entry is read at the pointer's page number <<12 plus the next lower index times the entry size.
- R5: Entry bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7, and the page number starts at bit 10. An entry with V clear faults. An entry with V set and R, W and X all clear is a pointer. A pointer found at the last level faults.
- R6: The leaf permission encodings W-only and W+X are reserved and fault.
- R7: A U leaf faults for an S-mode access unless the supervisor-user-access bit is set, and it always faults for an S-mode fetch. A leaf without U faults for a U-mode access.
- R8: A leaf found above the last level faults if the page-number bits it should cover are nonzero.
- R9: A load needs R, or X with the make-executable-readable bit set. A store needs W. A fetch needs X.
- R10: A successful leaf gets A set, and a store also gets D set. The entry is written back, using the same address and width it was read with, only if this changes it.
- R11: For a superpage, the low page-number bits of the physical address come from the virtual page number, and the page offset always comes from the virtual address.
- R12: The returned R grant is R, or X with the make-executable-readable bit set. The W grant is W only when the access is a store or the leaf was already dirty. The X grant is X.
- R13: An error response on any entry read or write-back ends the walk with `fault` and `fault_access` set. Every other fault has `fault_access` clear. On any fault, all three grants are 0.
- R14: `busy` is high from the cycle after acceptance until `done`. `done` lasts exactly one cycle. Each memory request lasts one cycle, with at most one request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken when idle) |
| req_vaddr | input | VA_W | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_mprv | input | 1 | Modify privilege for M-mode loads/stores |
| req_mpp | input | 2 | Privilege used when modify-privilege applies |
| xlat_mode | input | 2 | Scheme: 0 bare, 1 Sv32, 2 Sv39, 3 unsupported |
| xlat_root | input | PA_W-12 | Root table page number |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_req_we | output | 1 | Request is a write-back |
| mem_req_dword | output | 1 | 1: 8-byte access, 0: 4-byte access |
| mem_req_addr | output | PA_W | Entry address |
| mem_req_wdata | output | 64 | Write-back data (4-byte entries are replicated in both halves) |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_rdata | input | 64 | Aligned 8-byte read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation failed |
| fault_access | output | 1 | Failure was a memory error |
| out_paddr | output | PA_W | Physical address |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |

## Verification
The bench targets the edges of each walk. These are superpages at every level, both above and below the alignment boundary, and Sv32 entries that sit in the upper half of an 8-byte word. A walker that picks the wrong half or the wrong index width lands on an empty entry and faults. A walker that ORs in the wrong page-number bits returns a wrong address. The bench also counts memory reads and writes. This exposes a walker that writes back an unchanged entry, forgets D on a store, touches memory for a non-canonical address, or rejects an address with the high bits all ones. Privilege corner cases are driven one at a time: modify-privilege on a fetch, user pages from S-mode with and without the access bit, reserved leaf encodings, execute-only pages under the readable bit, and a read error midway through a walk. A wrong rule in any of these turns a fault into a grant or the reverse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PG_OFF     = 12;
    localparam int PTE_W      = 64;
    localparam int PPN_LSB    = 10;
    localparam int SV39_PPN_H = 53;
    localparam int SV32_PPN_H = 31;
    localparam int SV39_VA_W  = 39;
    localparam int IDX39_W    = 9;
    localparam int IDX32_W    = 10;

    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_A = 6;
    localparam int B_D = 7;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [1:0] XM_BARE = 2'd0;
    localparam logic [1:0] XM_SV32 = 2'd1;
    localparam logic [1:0] XM_SV39 = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WAIT_RD,
        ST_EVAL,
        ST_WRITE,
        ST_WAIT_WR,
        ST_DONE
    } state_e;
endpackage

// File: rtl/ptw_index_addr.sv
module ptw_index_addr
    import ptw_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 56
) (
    input  logic            sv39,
    input  logic [1:0]      level,
    input  logic [VA_W-1:0] vaddr,
    input  logic [PA_W-1:0] base,
    output logic [PA_W-1:0] pte_addr
);
    logic [IDX39_W-1:0] idx39;
    logic [IDX32_W-1:0] idx32;

    always_comb begin
        idx39    = IDX39_W'(vaddr >> (PG_OFF + IDX39_W * int'(level)));
        idx32    = IDX32_W'(vaddr >> (PG_OFF + IDX32_W * int'(level)));
        pte_addr = base + (sv39 ? (PA_W'(idx39) << 3) : (PA_W'(idx32) << 2));
    end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
    import ptw_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 56
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             sv39,
    input  logic [1:0]       level,
    input  acc_e             acc,
    input  logic             user_mode,
    input  logic             sum,
    input  logic             mxr,
    input  logic [VA_W-1:0]  vaddr,
    output logic             ptr,
    output logic             fail,
    output logic [PA_W-1:0]  pa,
    output logic             gr_r,
    output logic             gr_w,
    output logic             gr_x,
    output logic [PTE_W-1:0] pte_new,
    output logic             wb_need
);
    localparam int PPN_W = PA_W - PG_OFF;

    logic v, r, w, x, u, d;
    logic [PPN_W-1:0] ppn, vpn, low;
    logic [5:0] sh;
    logic unused_va;

    assign v = pte[B_V];
    assign r = pte[B_R];
    assign w = pte[B_W];
    assign x = pte[B_X];
    assign u = pte[B_U];
    assign d = pte[B_D];
    assign unused_va = ^vaddr[VA_W-1:PA_W];

    always_comb begin
        ppn  = sv39 ? PPN_W'(pte[SV39_PPN_H:PPN_LSB]) : PPN_W'(pte[SV32_PPN_H:PPN_LSB]);
        vpn  = PPN_W'(vaddr[PA_W-1:PG_OFF]);
        sh   = sv39 ? 6'(IDX39_W * int'(level)) : 6'(IDX32_W * int'(level));
        low  = ~({PPN_W{1'b1}} << sh);
        ptr  = v & ~r & ~w & ~x;
        fail = 1'b0;
        if (!v)                                                  fail = 1'b1;
        else if (ptr)                                            fail = 1'b0;
        else if (w && !r)                                        fail = 1'b1;
        else if (u && !user_mode && (!sum || acc == ACC_FETCH))  fail = 1'b1;
        else if (!u && user_mode)                                fail = 1'b1;
        else if (|(ppn & low))                                   fail = 1'b1;
        else if (acc == ACC_LOAD && !(r || (x && mxr)))          fail = 1'b1;
        else if (acc == ACC_STORE && !w)                         fail = 1'b1;
        else if (acc == ACC_FETCH && !x)                         fail = 1'b1;
        pa      = {ppn | (vpn & low), vaddr[PG_OFF-1:0]};
        gr_r    = r | (x & mxr);
        gr_w    = w & ((acc == ACC_STORE) | d);
        gr_x    = x;
        pte_new = pte | (PTE_W'(1) << B_A) | ((acc == ACC_STORE) ? (PTE_W'(1) << B_D) : '0);
        wb_need = (pte_new != pte);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_priv,
    input  logic              req_sum,
    input  logic              req_mxr,
    input  logic              req_mprv,
    input  logic [1:0]        req_mpp,
    input  logic [1:0]        xlat_mode,
    input  logic [PA_W-13:0]  xlat_root,
    output logic              busy,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic              mem_req_dword,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [63:0]       mem_rsp_rdata,
    output logic              done,
    output logic              fault,
    output logic              fault_access,
    output logic [PA_W-1:0]   out_paddr,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x
);
    localparam int PPN_W = PA_W - PG_OFF;

    state_e state, nxt;

    logic [1:0]       lvl;
    logic [PA_W-1:0]  base_q;
    logic [VA_W-1:0]  va_q;
    acc_e             acc_q;
    logic             user_q, mach_q, sum_q, mxr_q;
    logic [1:0]       mode_q;
    logic [PTE_W-1:0] pte_q, wb_q;
    logic [PA_W-1:0]  pa_q;
    logic             r_q, w_q, x_q, flt_q, fa_q;

    logic [1:0]       eff_priv;
    logic             sv39_q, bypass, bad_mode, noncanon;
    logic [PA_W-1:0]  pte_addr, pa_leaf;
    logic             ptr, fail, gr_r, gr_w, gr_x, wb_need;
    logic [PTE_W-1:0] pte_new, rsp_pte;
    logic [PPN_W-1:0] next_ppn;

    assign eff_priv = (req_priv == PRIV_M && acc_e'(req_acc) != ACC_FETCH && req_mprv)
                      ? req_mpp : req_priv;
    assign sv39_q   = (mode_q == XM_SV39);
    assign bypass   = mach_q || (mode_q == XM_BARE);
    assign bad_mode = (mode_q != XM_SV32) && (mode_q != XM_SV39);
    assign noncanon = sv39_q && !((&va_q[VA_W-1:SV39_VA_W-1]) || !(|va_q[VA_W-1:SV39_VA_W-1]));
    assign rsp_pte  = sv39_q ? mem_rsp_rdata
                             : {32'b0, pte_addr[2] ? mem_rsp_rdata[63:32] : mem_rsp_rdata[31:0]};
    assign next_ppn = sv39_q ? PPN_W'(pte_q[SV39_PPN_H:PPN_LSB]) : PPN_W'(pte_q[SV32_PPN_H:PPN_LSB]);

    ptw_index_addr #(.VA_W(VA_W), .PA_W(PA_W)) u_idx (
        .sv39     (sv39_q),
        .level    (lvl),
        .vaddr    (va_q),
        .base     (base_q),
        .pte_addr (pte_addr)
    );

    ptw_leaf_eval #(.VA_W(VA_W), .PA_W(PA_W)) u_leaf (
        .pte       (pte_q),
        .sv39      (sv39_q),
        .level     (lvl),
        .acc       (acc_q),
        .user_mode (user_q),
        .sum       (sum_q),
        .mxr       (mxr_q),
        .vaddr     (va_q),
        .ptr       (ptr),
        .fail      (fail),
        .pa        (pa_leaf),
        .gr_r      (gr_r),
        .gr_w      (gr_w),
        .gr_x      (gr_x),
        .pte_new   (pte_new),
        .wb_need   (wb_need)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid) nxt = ST_CHECK;
            ST_CHECK:   nxt = (bypass || bad_mode || noncanon) ? ST_DONE : ST_READ;
            ST_READ:    nxt = ST_WAIT_RD;
            ST_WAIT_RD: if (mem_rsp_valid) nxt = mem_rsp_err ? ST_DONE : ST_EVAL;
            ST_EVAL: begin
                if (ptr && lvl != 2'd0)  nxt = ST_READ;
                else if (fail || ptr)    nxt = ST_DONE;
                else if (wb_need)        nxt = ST_WRITE;
                else                     nxt = ST_DONE;
            end
            ST_WRITE:   nxt = ST_WAIT_WR;
            ST_WAIT_WR: if (mem_rsp_valid) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = (state == ST_READ) || (state == ST_WRITE);
        mem_req_we    = (state == ST_WRITE);
        mem_req_dword = sv39_q;
        mem_req_addr  = pte_addr;
        mem_req_wdata = sv39_q ? wb_q : {2{wb_q[31:0]}};
        done          = (state == ST_DONE);
        busy          = (state != ST_IDLE);
        fault         = flt_q;
        fault_access  = fa_q;
        out_paddr     = pa_q;
        perm_r        = r_q;
        perm_w        = w_q;
        perm_x        = x_q;
    end

    // walk datapath and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= '0; base_q <= '0; va_q <= '0; acc_q <= ACC_LOAD;
            user_q <= 1'b0; mach_q <= 1'b0; sum_q <= 1'b0; mxr_q <= 1'b0;
            mode_q <= XM_BARE; pte_q <= '0; wb_q <= '0; pa_q <= '0;
            r_q <= 1'b0; w_q <= 1'b0; x_q <= 1'b0; flt_q <= 1'b0; fa_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    acc_q  <= acc_e'(req_acc);
                    user_q <= (eff_priv == PRIV_U);
                    mach_q <= (eff_priv == PRIV_M);
                    sum_q  <= req_sum;
                    mxr_q  <= req_mxr;
                    mode_q <= xlat_mode;
                    base_q <= {xlat_root, {PG_OFF{1'b0}}};
                    lvl    <= (xlat_mode == XM_SV39) ? 2'd2 : 2'd1;
                    pa_q   <= '0;
                    r_q <= 1'b0; w_q <= 1'b0; x_q <= 1'b0;
                    flt_q <= 1'b0; fa_q <= 1'b0;
                end
                ST_CHECK: begin
                    if (bypass) begin
                        pa_q <= va_q[PA_W-1:0];
                        r_q <= 1'b1; w_q <= 1'b1; x_q <= 1'b1;
                    end else if (bad_mode || noncanon) begin
                        flt_q <= 1'b1;
                    end
                end
                ST_WAIT_RD: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        flt_q <= 1'b1;
                        fa_q  <= 1'b1;
                    end else begin
                        pte_q <= rsp_pte;
                    end
                end
                ST_EVAL: begin
                    if (ptr && lvl != 2'd0) begin
                        base_q <= {next_ppn, {PG_OFF{1'b0}}};
                        lvl    <= lvl - 2'd1;
                    end else if (fail || ptr) begin
                        flt_q <= 1'b1;
                    end else begin
                        pa_q <= pa_leaf;
                        r_q  <= gr_r;
                        w_q  <= gr_w;
                        x_q  <= gr_x;
                        wb_q <= pte_new;
                    end
                end
                ST_WAIT_WR: if (mem_rsp_valid && mem_rsp_err) begin
                    flt_q <= 1'b1;
                    fa_q  <= 1'b1;
                    r_q <= 1'b0; w_q <= 1'b0; x_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    a_r14_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> !(perm_r || perm_w || perm_x));

    a_r10_wb_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> mem_req_wdata[B_A]);

    a_r10_store_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && acc_q == ACC_STORE) |-> mem_req_wdata[B_D]);
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
    localparam int PA_W = 56;
    localparam logic [63:0] FV = 64'h01, FR = 64'h02, FW = 64'h04, FX = 64'h08,
                            FU = 64'h10, FA = 64'h40, FD = 64'h80;
    localparam logic [63:0] L39 = 64'h2_0000; // leaf page number 0x80 at bit 10
    localparam logic [63:0] VA39 = 64'h20_2345;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic req_valid = 0, req_sum = 0, req_mxr = 0, req_mprv = 0;
    logic [63:0] req_vaddr = '0;
    logic [1:0] req_acc = 0, req_priv = 0, req_mpp = 0, xlat_mode = 0;
    logic busy, mem_req_valid, mem_req_we, mem_req_dword, done, fault, fault_access;
    logic perm_r, perm_w, perm_x;
    logic [PA_W-1:0] mem_req_addr, out_paddr;
    logic [63:0] mem_req_wdata, mem_rsp_rdata;
    logic mem_rsp_valid, mem_rsp_err;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_priv(req_priv), .req_sum(req_sum), .req_mxr(req_mxr),
        .req_mprv(req_mprv), .req_mpp(req_mpp), .xlat_mode(xlat_mode),
        .xlat_root(44'h1), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_we(mem_req_we), .mem_req_dword(mem_req_dword), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rsp_rdata(mem_rsp_rdata), .done(done), .fault(fault), .fault_access(fault_access),
        .out_paddr(out_paddr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
    );

    // memory model: one-cycle response, 2048 x 64-bit words
    logic [63:0] mem [0:2047];
    logic wipe = 0, poke_en = 0, cnt_clr = 0, err_on = 0;
    logic [13:0] poke_addr = '0;
    logic [63:0] poke_data = '0;
    logic [PA_W-1:0] err_addr = '0;
    int rd_cnt = 0, wr_cnt = 0;

    always @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < 2048; i++) mem[i] <= '0;
        end else if (poke_en) begin
            mem[poke_addr[13:3]] <= poke_data;
        end
        if (cnt_clr) begin
            rd_cnt <= 0; wr_cnt <= 0;
        end
        mem_rsp_valid <= mem_req_valid;
        mem_rsp_err   <= mem_req_valid && err_on && (mem_req_addr == err_addr);
        mem_rsp_rdata <= mem[mem_req_addr[13:3]];
        if (mem_req_valid && !cnt_clr) begin
            if (mem_req_we) wr_cnt <= wr_cnt + 1;
            else            rd_cnt <= rd_cnt + 1;
        end
        if (mem_req_valid && mem_req_we) begin
            if (mem_req_dword)       mem[mem_req_addr[13:3]] <= mem_req_wdata;
            else if (mem_req_addr[2]) mem[mem_req_addr[13:3]][63:32] <= mem_req_wdata[31:0];
            else                     mem[mem_req_addr[13:3]][31:0]  <= mem_req_wdata[31:0];
        end
    end

    int nchk = 0, nerr = 0;
    logic [PA_W-1:0] c_pa;
    logic c_r, c_w, c_x, c_flt, c_fa, c_busy, c_done_after;
    int c_rd, c_wr;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_wipe();
        @(negedge clk); wipe = 1; @(negedge clk); wipe = 0;
    endtask

    task automatic poke64(input logic [13:0] a, input logic [63:0] v);
        @(negedge clk); poke_addr = a; poke_data = v; poke_en = 1;
        @(negedge clk); poke_en = 0;
    endtask

    task automatic poke32(input logic [13:0] a, input logic [31:0] v);
        logic [63:0] w;
        w = mem[a[13:3]];
        if (a[2]) w[63:32] = v; else w[31:0] = v;
        poke64(a, w);
    endtask

    task automatic build39(input logic [63:0] leaf);
        do_wipe();
        poke64(14'h1000, 64'h801);
        poke64(14'h2008, 64'hC01);
        poke64(14'h3010, leaf);
    endtask

    task automatic run(input logic [1:0] mode, input logic [63:0] va, input logic [1:0] acc,
                       input logic [1:0] priv, input logic sum, input logic mxr);
        int n;
        @(negedge clk); cnt_clr = 1;
        @(negedge clk); cnt_clr = 0;
        xlat_mode = mode; req_vaddr = va; req_acc = acc; req_priv = priv;
        req_sum = sum; req_mxr = mxr; req_valid = 1;
        @(negedge clk); req_valid = 0;
        c_busy = busy;
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk); n++;
        end
        chk("R14 done reached", {63'b0, done}, 64'd1);
        c_pa = out_paddr; c_r = perm_r; c_w = perm_w; c_x = perm_x;
        c_flt = fault; c_fa = fault_access; c_rd = rd_cnt; c_wr = wr_cnt;
        @(negedge clk);
        c_done_after = done;
    endtask

    task automatic expect_ok(input string tag, input logic [PA_W-1:0] pa, input logic r,
                             input logic w, input logic x, input int rd, input int wr);
        chk({tag, " fault"}, {63'b0, c_flt}, 64'd0);
        chk({tag, " paddr"}, {8'b0, c_pa}, {8'b0, pa});
        chk({tag, " rwx"}, {61'b0, c_r, c_w, c_x}, {61'b0, r, w, x});
        chk({tag, " reads"}, 64'(c_rd), 64'(rd));
        chk({tag, " writes"}, 64'(c_wr), 64'(wr));
    endtask

    task automatic expect_flt(input string tag, input logic fa, input int rd);
        chk({tag, " fault"}, {63'b0, c_flt}, 64'd1);
        chk({tag, " fault kind"}, {63'b0, c_fa}, {63'b0, fa});
        chk({tag, " R13 no grants"}, {61'b0, c_r, c_w, c_x}, 64'd0);
        chk({tag, " reads"}, 64'(c_rd), 64'(rd));
        chk({tag, " writes"}, 64'(c_wr), 64'd0);
    endtask

    task automatic t_reset();
        chk("R14 reset done", {63'b0, done}, 64'd0);
        chk("R14 reset busy", {63'b0, busy}, 64'd0);
        chk("R14 reset memreq", {63'b0, mem_req_valid}, 64'd0);
        chk("R13 reset fault", {63'b0, fault}, 64'd0);
    endtask

    task automatic t_bare();
        do_wipe();
        run(2'd0, 64'h0000_00AB_CDEF_1234, 2'd1, 2'd1, 0, 0);
        expect_ok("R1 bare", 56'h00AB_CDEF_1234, 1, 1, 1, 0, 0);
        run(2'd3, VA39, 2'd0, 2'd1, 0, 0);
        expect_flt("R1 unsupported scheme", 0, 0);
    endtask

    task automatic t_mmode();
        build39(L39 | FV | FR | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd3, 0, 0);
        expect_ok("R2 M bypass", VA39[55:0], 1, 1, 1, 0, 0);
        req_mprv = 1; req_mpp = 2'd1;
        run(2'd2, VA39, 2'd0, 2'd3, 0, 0);
        expect_ok("R2 mprv load", 56'h8_0345, 1, 0, 0, 3, 0);
        run(2'd2, VA39, 2'd2, 2'd3, 0, 0);
        expect_ok("R2 mprv fetch ignored", VA39[55:0], 1, 1, 1, 0, 0);
        req_mprv = 0; req_mpp = 2'd0;
    endtask

    task automatic t_canon();
        do_wipe();
        run(2'd2, 64'h0000_0040_0020_2345, 2'd0, 2'd1, 0, 0);
        expect_flt("R3 noncanonical", 0, 0);
        run(2'd2, 64'hFFFF_FFC0_0020_2345, 2'd0, 2'd1, 0, 0);
        expect_flt("R3 canonical high walks", 0, 1);
    endtask

    task automatic t_walk39();
        build39(L39 | FV | FR | FW | FA);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_ok("R4 R12 sv39 load clean", 56'h8_0345, 1, 0, 0, 3, 0);
        build39(L39 | FV | FR | FW | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_ok("R12 load dirty page", 56'h8_0345, 1, 1, 0, 3, 0);
        run(2'd2, VA39, 2'd1, 2'd1, 0, 0);
        expect_ok("R10 store no change", 56'h8_0345, 1, 1, 0, 3, 0);
    endtask

    task automatic t_ad();
        build39(L39 | FV | FR | FW);
        run(2'd2, VA39, 2'd1, 2'd1, 0, 0);
        expect_ok("R10 store sets AD", 56'h8_0345, 1, 1, 0, 3, 1);
        chk("R10 store pte", mem[14'h3010 >> 3], L39 | FV | FR | FW | FA | FD);
        build39(L39 | FV | FR);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_ok("R10 load sets A", 56'h8_0345, 1, 0, 0, 3, 1);
        chk("R10 load pte", mem[14'h3010 >> 3], L39 | FV | FR | FA);
    endtask

    task automatic t_invalid();
        build39(L39);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_flt("R5 invalid leaf", 0, 3);
        build39(L39 | FV);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_flt("R5 pointer at last level", 0, 3);
        poke64(14'h1000, 64'h0);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_flt("R5 invalid root", 0, 1);
    endtask

    task automatic t_reserved();
        build39(L39 | FV | FW | FA | FD);
        run(2'd2, VA39, 2'd1, 2'd1, 0, 0);
        expect_flt("R6 W only", 0, 3);
        build39(L39 | FV | FW | FX | FA | FD);
        run(2'd2, VA39, 2'd2, 2'd1, 0, 0);
        expect_flt("R6 W+X", 0, 3);
    endtask

    task automatic t_user();
        build39(L39 | FV | FR | FU | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_flt("R7 S on U page", 0, 3);
        run(2'd2, VA39, 2'd0, 2'd1, 1, 0);
        expect_ok("R7 S on U page with sum", 56'h8_0345, 1, 0, 0, 3, 0);
        run(2'd2, VA39, 2'd0, 2'd0, 0, 0);
        expect_ok("R7 U on U page", 56'h8_0345, 1, 0, 0, 3, 0);
        build39(L39 | FV | FX | FU | FA | FD);
        run(2'd2, VA39, 2'd2, 2'd1, 1, 0);
        expect_flt("R7 S fetch U page", 0, 3);
        build39(L39 | FV | FR | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd0, 0, 0);
        expect_flt("R7 U on S page", 0, 3);
    endtask

    task automatic t_perm();
        build39(L39 | FV | FR | FA | FD);
        run(2'd2, VA39, 2'd1, 2'd1, 0, 0);
        expect_flt("R9 store to RO", 0, 3);
        run(2'd2, VA39, 2'd2, 2'd1, 0, 0);
        expect_flt("R9 fetch non-X", 0, 3);
        build39(L39 | FV | FX | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_flt("R9 load X-only", 0, 3);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 1);
        expect_ok("R9 R12 load X-only mxr", 56'h8_0345, 1, 0, 1, 3, 0);
    endtask

    task automatic t_super();
        do_wipe();
        poke64(14'h1000, 64'h801);
        poke64(14'h2008, 64'h8_0000 | FV | FR | FW | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_ok("R11 2M superpage", 56'h20_2345, 1, 1, 0, 2, 0);
        poke64(14'h2008, 64'h8_0400 | FV | FR | FW | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_flt("R8 misaligned 2M", 0, 2);
        poke64(14'h1000, 64'h1000_0000 | FV | FR | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        expect_ok("R11 1G superpage", 56'h4020_2345, 1, 0, 0, 1, 0);
    endtask

    task automatic t_sv32();
        do_wipe();
        poke32(14'h1004, 32'h801);
        poke32(14'h200C, 32'h1_54CB);
        poke32(14'h2008, 32'h1234_5678);
        run(2'd1, 64'h40_37AB, 2'd2, 2'd1, 0, 0);
        expect_ok("R4 sv32 fetch", 56'h5_57AB, 1, 0, 1, 2, 0);
        poke32(14'h200C, 32'h1_540B);
        run(2'd1, 64'h40_37AB, 2'd0, 2'd1, 0, 0);
        expect_ok("R10 sv32 set A", 56'h5_57AB, 1, 0, 1, 2, 1);
        chk("R10 sv32 pte half", {32'b0, mem[14'h200C >> 3][63:32]}, 64'h1_544B);
        chk("R10 sv32 other half", {32'b0, mem[14'h2008 >> 3][31:0]}, 64'h1234_5678);
        poke32(14'h1004, 32'h10_00CB);
        run(2'd1, 64'h40_37AB, 2'd0, 2'd1, 0, 0);
        expect_ok("R11 sv32 superpage", 56'h40_37AB, 1, 0, 1, 1, 0);
        poke32(14'h1004, 32'h10_04CB);
        run(2'd1, 64'h40_37AB, 2'd0, 2'd1, 0, 0);
        expect_flt("R8 sv32 misaligned", 0, 1);
    endtask

    task automatic t_err();
        build39(L39 | FV | FR | FA | FD);
        err_addr = 56'h2008; err_on = 1;
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        err_on = 0;
        expect_flt("R13 read error", 1, 2);
    endtask

    task automatic t_handshake();
        build39(L39 | FV | FR | FA | FD);
        run(2'd2, VA39, 2'd0, 2'd1, 0, 0);
        chk("R14 busy during walk", {63'b0, c_busy}, 64'd1);
        chk("R14 done one cycle", {63'b0, c_done_after}, 64'd0);
        chk("R14 idle after", {63'b0, busy}, 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        nerr++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bare();
        t_mmode();
        t_canon();
        t_walk39();
        t_ad();
        t_invalid();
        t_reserved();
        t_user();
        t_perm();
        t_super();
        t_sv32();
        t_err();
        t_handshake();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule